// File: doc/BRIEF.md
# I2C Four-Channel Bus Switch Controller

This block is the digital control part of an I2C bus switch that connects an upstream two-wire bus to any set of four downstream channels. It acts as a slave on the upstream bus. It oversamples SCL and SDA on a fast system clock and finds START and STOP conditions. It shifts in an address byte and checks it against its own address, then either accepts control bytes (write) or returns its control register (read). It acknowledges by pulling SDA low through an open-drain output enable.

The low four bits of the 8-bit control register drive four channel-enable outputs, one per downstream channel. A synchronous power-on reset and an active-low fault-recovery reset both clear the register and the protocol state machine, so every channel is deselected. The fault-recovery reset lets a bus master recover from a hung bus. It takes effect asynchronously and is released in step with the clock.

Top module: `i2c_chan_switch`

## Requirements
- R1: After power-on reset (`rst` high) the control register is zero, so `chan_en` is 4'b0000, and `sda_oe` is 0 (SDA released).
- R2: When the address byte matches, the block pulls SDA low (`sda_oe`=1) for the whole high period of the ninth SCL pulse, and changes `sda_oe` only after an SCL falling edge, a START or a STOP.
- R3: On an address mismatch the block leaves SDA released on the ninth pulse (NACK). It acknowledges nothing and writes nothing until the next START or STOP.
- R4: In a write, the register takes the data byte only once its eighth bit has been sampled, and `chan_en` then equals register bits [3:0]. Bit i enables channel i.
- R5: In a read, the block shifts the register out MSB first, one bit per SCL pulse. A master NACK (SDA high on the ninth pulse) ends the read and leaves SDA released.
- R6: A repeated START during a byte aborts that byte without changing the register, and starts a new address phase.
- R7: Driving `fault_rst_n` low clears the register and the state machine, so `chan_en` becomes 0 and any transfer in progress is dropped.
- R8: A STOP (SDA rising while SCL is high) returns the block to idle with SDA released.
- R9: The 7-bit slave address is `ADDR_BASE` with its low `PIN_W` bits replaced by `addr_sel`. Bit 0 of the address byte (the last bit sent) selects write (0) or read (1). Bytes travel MSB first.
- R10: Each data byte that follows a matched write address is acknowledged and loaded, so the last byte before a STOP is the one that remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst | input | 1 | Synchronous active-high power-on reset |
| fault_rst_n | input | 1 | Active-low fault-recovery reset, asynchronous assert |
| addr_sel | input | PIN_W (2) | Pin-selected low bits of the slave address |
| scl_i | input | 1 | Upstream SCL level |
| sda_i | input | 1 | Upstream SDA level as seen on the wire |
| sda_oe | output | 1 | 1 pulls SDA low (open drain), 0 releases it |
| chan_en | output | CH_N (4) | Downstream channel enables, register bits [3:0] |

## Verification
Directed transfers come first: a matched write, a readback, a mismatched address followed by a data byte, a multi-byte write, and a repeated START part way through a byte. These separate the ACK path, the register-load timing and the ignore behaviour. A fault reset given in the middle of an address phase and then checked by a readback shows that both the register and the state machine are cleared. Random transfers then mix the pin-selected address, matching and non-matching targets, read and write direction, and data values. They check ACK, `chan_en` and the readback against a bench model of the register.

// File: rtl/sw_pkg.sv
package sw_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } sw_state_e;

    // Conditioned view of one bus line after synchronization
    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } line_ev_t;

    // Build the slave address from a base value and pin inputs
    function automatic logic [ADDR_W-1:0] make_addr(
        input logic [ADDR_W-1:0] base,
        input logic [ADDR_W-1:0] pins,
        input logic [ADDR_W-1:0] mask
    );
        return (base & ~mask) | (pins & mask);
    endfunction

endpackage

// File: rtl/sw_reset_gen.sv
module sw_reset_gen #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por,
    input  logic fault_rst_n,
    output logic rst_out
);

    logic [STAGES-1:0] hold_q;

    // Asynchronous assert, clocked release of the fault reset
    always_ff @(posedge clk or negedge fault_rst_n) begin
        if (!fault_rst_n) begin
            hold_q <= '1;
        end else begin
            hold_q <= {hold_q[STAGES-2:0], 1'b0};
        end
    end

    assign rst_out = por | hold_q[STAGES-1];

    always @(posedge clk) begin
        if (fault_rst_n === 1'b0) begin
            AST_FAULT_FORCES_RST: assert (rst_out); // R7
        end
    end

endmodule

// File: rtl/sw_line_sync.sv
module sw_line_sync #(
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_i,
    output sw_pkg::line_ev_t ev
);

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], line_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign ev.level = sync_q[STAGES-1];
    assign ev.rise  = sync_q[STAGES-1] & ~prev_q;
    assign ev.fall  = ~sync_q[STAGES-1] & prev_q;

endmodule

// File: rtl/sw_slave_fsm.sv
module sw_slave_fsm
    import sw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          scl,
    input  line_ev_t          sda,
    input  logic [ADDR_W-1:0] my_addr,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic              sda_oe
);

    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

    sw_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] shreg;
    logic              rw_q;
    logic              start;
    logic              stop;
    logic              last_rise;

    // Bus conditions: SDA moves while SCL stays high
    assign start     = scl.level & ~scl.rise & sda.fall;
    assign stop      = scl.level & ~scl.rise & sda.rise;
    assign last_rise = scl.rise & (cnt == LAST_BIT);

    assign wr_data = {shreg[BYTE_W-2:0], sda.level};
    assign wr_en   = (state == ST_WDATA) & last_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            shreg  <= '0;
            rw_q   <= 1'b0;
            sda_oe <= 1'b0;
        end else if (start) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else if (stop) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            sda_oe <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR: begin
                    if (scl.rise) begin
                        shreg <= wr_data;
                        cnt   <= cnt + 1'b1;
                        if (last_rise) begin
                            if (shreg[ADDR_W-1:0] == my_addr) begin
                                state <= ST_ADDR_ACK;
                                rw_q  <= sda.level;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                    end
                end
                ST_ADDR_ACK, ST_WACK: begin
                    if (scl.fall) begin
                        if (!sda_oe) begin
                            sda_oe <= 1'b1;
                        end else begin
                            cnt <= '0;
                            if (state == ST_WACK || !rw_q) begin
                                state  <= ST_WDATA;
                                sda_oe <= 1'b0;
                            end else begin
                                state  <= ST_RDATA;
                                shreg  <= rd_data;
                                sda_oe <= ~rd_data[BYTE_W-1];
                            end
                        end
                    end
                end
                ST_WDATA: begin
                    if (scl.rise) begin
                        shreg <= wr_data;
                        cnt   <= cnt + 1'b1;
                        if (last_rise) begin
                            state <= ST_WACK;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl.rise) begin
                        cnt <= cnt + 1'b1;
                    end else if (scl.fall) begin
                        if (cnt == ALL_BITS) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RACK;
                            cnt    <= '0;
                        end else if (cnt != '0) begin
                            shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~shreg[BYTE_W-2];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl.rise) begin
                        if (sda.level) begin
                            state <= ST_IGNORE;
                        end else begin
                            cnt <= CNT_W'(1);
                        end
                    end else if (scl.fall && cnt == CNT_W'(1)) begin
                        state  <= ST_RDATA;
                        cnt    <= '0;
                        shreg  <= rd_data;
                        sda_oe <= ~rd_data[BYTE_W-1];
                    end
                end
                default: begin
                end
            endcase
        end
    end

    AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        !(scl.fall || start || stop) |=> $stable(sda_oe)); // R2

    AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> (!sda_oe && !wr_en)); // R3

    AST_START_ABORT: assert property (@(posedge clk) disable iff (rst)
        start |=> (state == ST_ADDR)); // R6

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
        stop |=> (state == ST_IDLE && !sda_oe)); // R8

endmodule

// File: rtl/sw_ctrl_reg.sv
module sw_ctrl_reg
    import sw_pkg::*;
#(
    parameter int CH_N = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] ctrl_q,
    output logic [CH_N-1:0]   chan_en
);

    logic rst_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        rst_d <= rst;
    end

    assign chan_en = ctrl_q[CH_N-1:0];

    always @(posedge clk) begin
        if (rst_d === 1'b1 && rst === 1'b0) begin
            AST_RST_CLEAR: assert (ctrl_q == '0); // R1
        end
    end

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctrl_q)); // R4

    AST_REG_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ctrl_q == $past(wr_data))); // R4

endmodule

// File: rtl/i2c_chan_switch.sv
module i2c_chan_switch
    import sw_pkg::*;
#(
    parameter logic [6:0] ADDR_BASE   = 7'h70,
    parameter int         PIN_W       = 2,
    parameter int         CH_N        = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fault_rst_n,
    input  logic [PIN_W-1:0] addr_sel,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    output logic [CH_N-1:0]  chan_en
);

    localparam int LINE_N = 2;
    localparam logic [ADDR_W-1:0] PIN_MASK = ADDR_W'((1 << PIN_W) - 1);

    logic              rst_int;
    logic [LINE_N-1:0] raw_lines;
    line_ev_t          line_ev [LINE_N];
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] ctrl_q;
    logic [ADDR_W-1:0] my_addr;

    assign raw_lines = {sda_i, scl_i};
    assign my_addr   = make_addr(ADDR_BASE, ADDR_W'(addr_sel), PIN_MASK);

    sw_reset_gen #(
        .STAGES (SYNC_STAGES)
    ) u_rst (
        .clk         (clk),
        .por         (rst),
        .fault_rst_n (fault_rst_n),
        .rst_out     (rst_int)
    );

    for (genvar g = 0; g < LINE_N; g++) begin : g_line
        sw_line_sync #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk    (clk),
            .rst    (rst_int),
            .line_i (raw_lines[g]),
            .ev     (line_ev[g])
        );
    end

    sw_slave_fsm u_fsm (
        .clk     (clk),
        .rst     (rst_int),
        .scl     (line_ev[0]),
        .sda     (line_ev[1]),
        .my_addr (my_addr),
        .rd_data (ctrl_q),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .sda_oe  (sda_oe)
    );

    sw_ctrl_reg #(
        .CH_N (CH_N)
    ) u_reg (
        .clk     (clk),
        .rst     (rst_int),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q),
        .chan_en (chan_en)
    );

endmodule

// File: tb/i2c_chan_switch_bench.sv
`timescale 1ns/1ps
module i2c_chan_switch_bench;

    localparam int Q = 6;
    localparam logic [6:0] BASE = 7'h70;
    localparam int TIMEOUT_CYC = 190000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       fault_rst_n = 1'b1;
    logic [1:0] addr_sel = 2'b01;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [3:0] chan_en;
    wire        sda_bus = sda_m & ~sda_oe;

    int checks = 0;
    int fails = 0;
    logic [7:0] exp_reg = 8'h00;

    always #2.5 clk = ~clk;

    i2c_chan_switch u_i2c_chan_switch (
        .clk         (clk),
        .rst         (rst),
        .fault_rst_n (fault_rst_n),
        .addr_sel    (addr_sel),
        .scl_i       (scl_m),
        .sda_i       (sda_bus),
        .sda_oe      (sda_oe),
        .chan_en     (chan_en)
    );

    function automatic logic [6:0] dev_addr(input logic [1:0] sel);
        return {BASE[6:2], sel};
    endfunction

    function automatic logic [3:0] exp_chan(input logic [7:0] r);
        return r[3:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b;    tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        b = sda_bus;  tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic write_byte(input logic [7:0] d, output logic acked);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(a);
        acked = ~a;
    endtask

    task automatic read_byte(output logic [7:0] d, input logic nack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(nack);
    endtask

    initial begin
        tick(TIMEOUT_CYC);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic       ack;
        logic [7:0] rd;
        logic [6:0] tgt;
        logic       is_match;
        logic       is_read;
        logic [7:0] dat;
        void'($urandom(32'd1234));

        tick(5);
        rst = 1'b0;
        tick(2);
        check("R1 chan_en after reset", chan_en, 4'h0);
        check("R1 sda_oe after reset", sda_oe, 1'b0);

        // Matched write
        bus_start();
        write_byte({dev_addr(2'b01), 1'b0}, ack);
        check("R2 R9 address ack", ack, 1'b1);
        write_byte(8'hA5, ack);
        check("R4 data ack", ack, 1'b1);
        exp_reg = 8'hA5;
        check("R4 chan_en after write", chan_en, exp_chan(exp_reg));
        bus_stop();
        tick(4);
        check("R8 released after stop", sda_oe, 1'b0);

        // Readback
        bus_start();
        write_byte({dev_addr(2'b01), 1'b1}, ack);
        check("R5 read address ack", ack, 1'b1);
        read_byte(rd, 1'b1);
        check("R5 read data MSB first", rd, exp_reg);
        tick(4);
        check("R5 released after master nack", sda_oe, 1'b0);
        bus_stop();

        // Mismatched address
        bus_start();
        write_byte({dev_addr(2'b10), 1'b0}, ack);
        check("R3 mismatch nack", ack, 1'b0);
        write_byte(8'h0F, ack);
        check("R3 data ignored nack", ack, 1'b0);
        check("R3 chan_en unchanged", chan_en, exp_chan(exp_reg));
        bus_stop();

        // Pin-selected address change
        addr_sel = 2'b10;
        bus_start();
        write_byte({dev_addr(2'b10), 1'b0}, ack);
        check("R9 new pin address ack", ack, 1'b1);
        // Multi-byte write
        write_byte(8'h03, ack);
        exp_reg = 8'h03;
        check("R10 first byte", chan_en, exp_chan(exp_reg));
        write_byte(8'h3C, ack);
        check("R10 second byte ack", ack, 1'b1);
        exp_reg = 8'h3C;
        check("R10 second byte", chan_en, exp_chan(exp_reg));
        bus_stop();

        // Repeated START inside a data byte
        bus_start();
        write_byte({dev_addr(2'b10), 1'b0}, ack);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_start();
        check("R6 register unchanged by aborted byte", chan_en, exp_chan(exp_reg));
        write_byte({dev_addr(2'b10), 1'b1}, ack);
        check("R6 new address phase ack", ack, 1'b1);
        read_byte(rd, 1'b1);
        check("R6 readback after abort", rd, exp_reg);
        bus_stop();

        // Fault reset in the middle of an address phase
        bus_start();
        for (int i = 0; i < 3; i++) send_bit(1'b1);
        fault_rst_n = 1'b0;
        tick(3);
        check("R7 chan_en cleared by fault reset", chan_en, 4'h0);
        fault_rst_n = 1'b1;
        exp_reg = 8'h00;
        tick(4);
        bus_stop();
        bus_start();
        write_byte({dev_addr(2'b10), 1'b1}, ack);
        check("R7 ack after fault reset", ack, 1'b1);
        read_byte(rd, 1'b1);
        check("R7 register zero after fault reset", rd, 8'h00);
        bus_stop();

        // Random transfers
        for (int it = 0; it < 40; it++) begin
            addr_sel = 2'($urandom);
            is_match = $urandom_range(0, 1) == 1;
            is_read  = $urandom_range(0, 2) == 0;
            dat      = 8'($urandom);
            tgt      = is_match ? dev_addr(addr_sel) : (dev_addr(addr_sel) ^ 7'(1 << $urandom_range(0, 6)));
            bus_start();
            write_byte({tgt, is_read}, ack);
            check(is_match ? "R2 random ack" : "R3 random nack", ack, is_match);
            if (is_match && is_read) begin
                read_byte(rd, 1'b1);
                check("R5 random read", rd, exp_reg);
            end else if (!is_read) begin
                write_byte(dat, ack);
                check("R4 random data ack", ack, is_match);
                if (is_match) exp_reg = dat;
                check("R4 random chan_en", chan_en, exp_chan(exp_reg));
            end
            bus_stop();
            tick(2);
            check("R8 random idle release", sda_oe, 1'b0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule